// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block generates the time base of one PWM channel. A two-stage clock prescaler turns the system clock into a one-clock `tick` enable. On every tick, an up-counter steps from zero towards an active period value and then wraps back to zero. A single-cycle zero event marks each tick on which the counter sits at zero.

The period value can be used in two ways. In shadowed mode, software writes a staging copy, and that copy moves into the active period at the next zero event. In direct mode, a write lands in the active period at once.

The counter can be reloaded from a phase register, so several time bases can be aligned. A reload is triggered by a rising edge on the external sync input or by a one-shot pulse forced from software. A selectable sync output lets the next module in a chain follow this one.

A three-register write/read port sets up the block: control at address 0, period at address 1 and phase at address 2.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the control register reads 0x0020. Its field layout is [10:8] clock-divider code, [7:5] high-speed-divider code, [4] software sync, [3:2] sync-output select, [1] period-direct mode, [0] phase enable. So after reset both dividers decode to a total of /2, shadowed mode is selected and the sync select is 00. Period, phase and counter are all 0 after reset.
- R2: `tick` is high for one clock in every P clocks. P = C × H, where C = 2^code of the clock-divider field (1 to 128), and H = 1 for code 0 or 2 × code otherwise (2 to 14). Any control write restarts the prescaler, so the first tick comes in the P-th cycle after the write edge.
- R3: On a tick the counter adds one. If the counter is already greater than or equal to the active period, it goes to 0 instead. Without a tick or a phase load the counter holds its value.
- R4: `zero_evt` is high exactly in the cycles where `tick` is high and the counter is 0.
- R5: With period-direct = 0, period writes and reads use the staging copy. The active period takes the staging value on the clock edge that follows a zero event.
- R6: With period-direct = 1, a period write updates the active period (and the staging copy) at its own edge, and reads return the active period.
- R7: With phase enable = 1, a sync event loads the phase register into the counter on the next clock edge.
- R8: With phase enable = 0, sync events leave the counter untouched.
- R9: The sync input is edge-detected. A level held high gives one sync event, in the cycle it first rises.
- R10: A phase load wins over a wrap or an increment happening in the same cycle.
- R11: A control write with bit 4 set, made while the current sync-output select is 00, gives a sync pulse in the single cycle after the write edge. Bit 4 always reads back as 0.
- R12: A software sync request made while the sync-output select is not 00 has no effect.
- R13: `sync_out` follows the selected source in the same cycle. Select 00 gives the sync event (input edge or software pulse), 01 gives `zero_evt`, 10 gives `cmpb_hit`, and 11 holds the output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 period, 2 phase) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| sync_in | input | 1 | External sync request (level; rising edge counts) |
| cmpb_hit | input | 1 | Counter-equals-compare-B indication for sync output |
| count | output | CNT_W | Time-base counter value |
| tick | output | 1 | Prescaled time-base enable |
| zero_evt | output | 1 | Counter-at-zero event on a tick |
| sync_out | output | 1 | Selected sync output for chaining |

## Verification
The hardest case to reach is a sync event that lands on the very cycle the counter would wrap. It is also hard to catch a staged period change at the exact zero event that commits it. Both depend on the free-running prescaler phase.

The stimulus makes this timing deterministic in three steps. First, it parks the prescaler at its largest divide while period and phase are written. Then a final control write restarts the prescaler, which pins every later tick to a known cycle. Finally, sync edges and period writes are placed a counted number of edges after that write, for example on the cycle the counter holds the period value.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;

    // Largest combined divide: 14 (high-speed) x 128 (clock divider)
    localparam int PRE_MAX = 14 * 128;
    localparam int PRE_W   = $clog2(PRE_MAX);
    localparam int REG_AW  = 2;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_PRD   = 2'd1,
        ADDR_PHASE = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_ZERO = 2'd1,
        SEL_CMPB = 2'd2,
        SEL_OFF  = 2'd3
    } sync_sel_e;

    typedef struct packed {
        logic [2:0] ck_div;
        logic [2:0] hs_div;
        logic       sw_sync;
        sync_sel_e  sync_sel;
        logic       prd_direct;
        logic       phase_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{
        ck_div:     3'd0,
        hs_div:     3'd1,
        sw_sync:    1'b0,
        sync_sel:   SEL_PASS,
        prd_direct: 1'b0,
        phase_en:   1'b0
    };

    // Reload value of the single prescale counter: (H * C) - 1
    function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] ck, input logic [2:0] hs);
        logic [PRE_W-1:0] hs_f;
        logic [PRE_W-1:0] prod;
        hs_f = (hs == 3'd0) ? PRE_W'(1) : PRE_W'({hs, 1'b0});
        prod = hs_f << ck;
        return prod - PRE_W'(1);
    endfunction

endpackage

// File: rtl/ptb_prescale.sv
`timescale 1ns/1ps
module ptb_prescale
    import ptb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ck_div,
    input  logic [2:0] hs_div,
    input  logic       restart,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t       s_d, s_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        s_d   = s_q;
        limit = pre_limit(ck_div, hs_div);
        // >= so that a smaller divide chosen mid-count still fires promptly
        tick  = (s_q.pre >= limit);
        if (restart) begin
            s_d.pre = '0;
        end else if (tick) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ptb_sync.sv
`timescale 1ns/1ps
module ptb_sync
    import ptb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_in,
    input  logic      sw_req,
    input  sync_sel_e sel,
    input  logic      zero_evt,
    input  logic      cmpb_hit,
    output logic      sync_evt,
    output logic      sw_pulse,
    output logic      sync_out
);

    typedef struct packed {
        logic sw;
    } sync_state_t;

    sync_state_t s_d, s_q;
    logic        in_q;
    logic        in_rise;

    // Delayed copy of the input, free-running so it always mirrors the last edge
    always_ff @(posedge clk) begin
        in_q <= sync_in;
    end

    always_comb begin
        s_d      = s_q;
        // software request counts only while the output passes the sync event through
        s_d.sw   = sw_req && (sel == SEL_PASS);
        in_rise  = sync_in && !in_q;
        sw_pulse = s_q.sw;
        sync_evt = in_rise || s_q.sw;
        unique case (sel)
            SEL_PASS: sync_out = sync_evt;
            SEL_ZERO: sync_out = zero_evt;
            SEL_CMPB: sync_out = cmpb_hit;
            default:  sync_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ptb_counter.sv
`timescale 1ns/1ps
module ptb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] phase,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             prd_direct,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt,
    output logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] prd_stage
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] stage;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        zero_evt = tick && (s_q.cnt == '0);

        // counter: phase load has priority over the tick step
        if (load) begin
            s_d.cnt = phase;
        end else if (tick) begin
            if (s_q.cnt >= s_q.act) begin
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end

        // period: staged copy commits on a zero event in shadowed mode
        if (zero_evt && !prd_direct) begin
            s_d.act = s_q.stage;
        end
        if (prd_we) begin
            s_d.stage = prd_wdata;
            if (prd_direct) begin
                s_d.act = prd_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count     = s_q.cnt;
    assign prd_act   = s_q.act;
    assign prd_stage = s_q.stage;

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sync_in,
    input  logic              cmpb_hit,
    output logic [CNT_W-1:0]  count,
    output logic              tick,
    output logic              zero_evt,
    output logic              sync_out
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] phase;
    } regs_t;

    regs_t            r_d, r_q;
    ctrl_t            ctrl_q;
    ctrl_t            wr_ctrl;
    logic [CNT_W-1:0] phase_q;
    logic             ctrl_wr;
    logic             prd_wr;
    logic             phase_wr;
    logic             sw_req;
    logic             sync_evt;
    logic             sw_pulse;
    logic             cnt_load;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] prd_stage;

    assign ctrl_q  = r_q.ctrl;
    assign phase_q = r_q.phase;

    always_comb begin
        r_d      = r_q;
        wr_ctrl  = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        ctrl_wr  = bus_we && (bus_addr == ADDR_CTRL);
        prd_wr   = bus_we && (bus_addr == ADDR_PRD);
        phase_wr = bus_we && (bus_addr == ADDR_PHASE);
        sw_req   = ctrl_wr && wr_ctrl.sw_sync;
        if (ctrl_wr) begin
            r_d.ctrl         = wr_ctrl;
            r_d.ctrl.sw_sync = 1'b0;
        end
        if (phase_wr) begin
            r_d.phase = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= CTRL_RST;
            r_q.phase <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            ADDR_PRD:   bus_rdata = DATA_W'(ctrl_q.prd_direct ? prd_act : prd_stage);
            ADDR_PHASE: bus_rdata = DATA_W'(phase_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign cnt_load = sync_evt && ctrl_q.phase_en;

    ptb_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ck_div  (ctrl_q.ck_div),
        .hs_div  (ctrl_q.hs_div),
        .restart (ctrl_wr),
        .tick    (tick)
    );

    ptb_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .sw_req   (sw_req),
        .sel      (ctrl_q.sync_sel),
        .zero_evt (zero_evt),
        .cmpb_hit (cmpb_hit),
        .sync_evt (sync_evt),
        .sw_pulse (sw_pulse),
        .sync_out (sync_out)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (cnt_load),
        .phase      (phase_q),
        .prd_we     (prd_wr),
        .prd_wdata  (bus_wdata[CNT_W-1:0]),
        .prd_direct (ctrl_q.prd_direct),
        .count      (count),
        .zero_evt   (zero_evt),
        .prd_act    (prd_act),
        .prd_stage  (prd_stage)
    );

endmodule

// File: rtl/ptb_checker.sv
`timescale 1ns/1ps
module ptb_checker
    import ptb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sync_in,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input logic              zero_evt,
    input logic              sync_out,
    input logic              cnt_load,
    input logic              sw_pulse,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  phase_q,
    input logic [CNT_W-1:0]  prd_act,
    input logic [CNT_W-1:0]  prd_stage
);

    // R3: step on a tick
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load && (count < prd_act)) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

    // R3: wrap at or above the active period
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load && (count >= prd_act)) |=> (count == '0));

    // R3: hold without tick or load
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_load) |=> (count == $past(count)));

    // R4: zero event only on a tick at zero
    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (tick && (count == '0)));

    // R5: staged period commits after a zero event in shadowed mode
    p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !ctrl_q.prd_direct) |=> (prd_act == $past(prd_stage)));

    // R7 and R10: a load takes the phase value
    p_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (count == $past(phase_q)));

    // R9: a held sync level gives no further load
    p_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && $past(sync_in) && !sw_pulse) |-> !cnt_load);

    // R11: the software pulse only follows a pass-through selection
    p_swsel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pulse |-> ($past(ctrl_q.sync_sel) == SEL_PASS));

    // R11: the software sync bit never reads back as 1
    p_swread_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> !bus_rdata[4]);

    // R13: disabled output stays low
    p_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.sync_sel == SEL_OFF) |-> !sync_out);

endmodule

bind pwm_timebase ptb_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sync_in   (sync_in),
    .count     (count),
    .tick      (tick),
    .zero_evt  (zero_evt),
    .sync_out  (sync_out),
    .cnt_load  (cnt_load),
    .sw_pulse  (sw_pulse),
    .ctrl_q    (ctrl_q),
    .phase_q   (phase_q),
    .prd_act   (prd_act),
    .prd_stage (prd_stage)
);

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              sync_in = 1'b0;
    logic              cmpb_hit = 1'b0;
    logic [CNT_W-1:0]  count;
    logic              tick;
    logic              zero_evt;
    logic              sync_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timebase #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_in),
        .cmpb_hit  (cmpb_hit),
        .count     (count),
        .tick      (tick),
        .zero_evt  (zero_evt),
        .sync_out  (sync_out)
    );

    // care bits: [0] count, [1] tick, [2] zero_evt, [3] sync_out
    typedef struct {
        string    req;
        int       cnt;
        bit       tk;
        bit       zr;
        bit       sy;
        bit [3:0] care;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic push(input string req, input int c, input bit t, input bit z,
                        input bit s, input bit [3:0] care);
        exp_t e;
        e.req = req; e.cnt = c; e.tk = t; e.zr = z; e.sy = s; e.care = care;
        sb.push_back(e);
    endtask

    // Monitor: one expected item per falling edge
    always @(negedge clk) begin : mon
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            if (e.care[0]) check({e.req, " count"}, int'(count), e.cnt);
            if (e.care[1]) check({e.req, " tick"}, int'(tick), int'(e.tk));
            if (e.care[2]) check({e.req, " zero_evt"}, int'(zero_evt), int'(e.zr));
            if (e.care[3]) check({e.req, " sync_out"}, int'(sync_out), int'(e.sy));
        end
    end

    function automatic int mk(int ck, int hs, int sel, int pd, int pe);
        return (ck << 8) | (hs << 5) | (sel << 2) | (pd << 1) | pe;
    endfunction

    function automatic int pfac(int ck, int hs);
        return (1 << ck) * ((hs == 0) ? 1 : 2 * hs);
    endfunction

    task automatic drain();
        wait (sb.size() == 0);
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk);
        #1;
        bus_we    = 1'b1;
        bus_addr  = 2'(a);
        bus_wdata = DATA_W'(d);
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        bus_we   = 1'b0;
        sync_in  = 1'b0;
        cmpb_hit = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Park the prescaler at its largest divide, load period and phase,
    // then a final control write restarts it: that edge is n = 0.
    task automatic setup(input int ck, input int hs, input int prd, input int ph,
                         input int sel, input int pd, input int pe);
        do_reset();
        wr(0, mk(7, 7, 0, 1, 0));
        wr(1, prd);
        wr(2, ph);
        wr(0, mk(ck, hs, sel, pd, pe));
    endtask

    // Expected free count starting from 0 at n = 0
    task automatic push_count(input int p, input int prd, input int num, input string req);
        for (int n = 0; n < num; n++) begin
            int c;
            bit t;
            c = (n / p) % (prd + 1);
            t = ((n % p) == (p - 1));
            push(req, c, t, t && (c == 0), 1'b0, 4'b0111);
        end
    endtask

    initial begin
        // ---- R1: reset values ----
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        bus_addr = 2'd0; #0.5;
        check("R1 ctrl reset", int'(bus_rdata), 32'h20);
        bus_addr = 2'd1; #0.5;
        check("R1 period reset", int'(bus_rdata), 0);
        bus_addr = 2'd2; #0.5;
        check("R1 phase reset", int'(bus_rdata), 0);
        check("R1 count reset", int'(count), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) begin
            push("R1 R2 reset divide", 0, (n % 2) == 1, (n % 2) == 1, 1'b0, 4'b0111);
        end
        drain();

        // ---- R2 R3 R4: prescaler and free counting ----
        setup(0, 0, 3, 0, 0, 1, 0);
        push_count(pfac(0, 0), 3, 12, "R2 R3 R4 div1");
        drain();
        setup(1, 2, 2, 0, 0, 1, 0);
        push_count(pfac(1, 2), 2, 40, "R2 R3 R4 div8");
        drain();
        setup(0, 7, 1, 0, 0, 1, 0);
        push_count(pfac(0, 7), 1, 60, "R2 R3 R4 div14");
        drain();
        setup(7, 1, 1, 0, 0, 1, 0);
        push_count(pfac(7, 1), 1, 600, "R2 R3 div256");
        drain();

        // ---- R5: staged period ----
        setup(0, 0, 5, 0, 0, 0, 0);
        wr(1, 2);
        check("R5 read staged period", int'(bus_rdata), 2);
        begin
            int seq5 [11] = '{2, 3, 4, 5, 0, 1, 2, 0, 1, 2, 0};
            foreach (seq5[i]) push("R5 staged commit", seq5[i], 1'b0, 1'b0, 1'b0, 4'b0001);
        end
        drain();

        // ---- R6: direct period ----
        setup(0, 0, 5, 0, 0, 1, 0);
        wr(1, 2);
        check("R6 read active period", int'(bus_rdata), 2);
        begin
            int seq6 [5] = '{2, 0, 1, 2, 0};
            foreach (seq6[i]) push("R6 direct period", seq6[i], 1'b0, 1'b0, 1'b0, 4'b0001);
        end
        drain();

        // ---- R3: counter above a newly written smaller period wraps ----
        setup(0, 0, 9, 0, 0, 1, 0);
        repeat (3) @(posedge clk);
        wr(1, 2);
        push("R3 above period", 5, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R3 above period", 0, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R3 above period", 1, 1'b0, 1'b0, 1'b0, 4'b0001);
        drain();

        // ---- R7 R9: phase load on sync edge, held level ignored ----
        setup(0, 0, 9, 7, 0, 1, 1);
        @(posedge clk);
        #1;
        sync_in = 1'b1;
        push("R7 R13 sync edge", 1, 1'b0, 1'b0, 1'b1, 4'b1001);
        push("R7 phase load", 7, 1'b0, 1'b0, 1'b0, 4'b1001);
        push("R9 held level", 8, 1'b0, 1'b0, 1'b0, 4'b1001);
        push("R9 held level", 9, 1'b0, 1'b0, 1'b0, 4'b1001);
        push("R9 held level", 0, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R9 held level", 1, 1'b0, 1'b0, 1'b0, 4'b0001);
        repeat (3) @(posedge clk);
        #1;
        sync_in = 1'b0;
        drain();

        // ---- R8: phase disabled ----
        setup(0, 0, 9, 7, 0, 1, 0);
        @(posedge clk);
        #1;
        sync_in = 1'b1;
        push("R8 R13 sync no load", 1, 1'b0, 1'b0, 1'b1, 4'b1001);
        push("R8 sync no load", 2, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R8 sync no load", 3, 1'b0, 1'b0, 1'b0, 4'b0001);
        drain();

        // ---- R10: load beats wrap ----
        setup(0, 0, 3, 2, 0, 1, 1);
        repeat (3) @(posedge clk);
        #1;
        sync_in = 1'b1;
        push("R10 at period", 3, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R10 load over wrap", 2, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R10 after load", 3, 1'b0, 1'b0, 1'b0, 4'b0001);
        push("R10 after load", 0, 1'b0, 1'b0, 1'b0, 4'b0001);
        drain();
        sync_in = 1'b0;

        // ---- R11: software sync ----
        setup(0, 0, 9, 5, 0, 1, 1);
        wr(0, mk(0, 0, 0, 1, 1) | 32'h10);
        check("R11 sw bit reads 0", int'(bus_rdata), mk(0, 0, 0, 1, 1));
        push("R11 R13 sw pulse", 2, 1'b0, 1'b0, 1'b1, 4'b1001);
        push("R11 sw load", 5, 1'b0, 1'b0, 1'b0, 4'b1001);
        push("R11 single pulse", 6, 1'b0, 1'b0, 1'b0, 4'b1001);
        drain();

        // ---- R12: software sync ignored off pass-through ----
        setup(0, 0, 9, 5, 1, 1, 1);
        wr(0, mk(0, 0, 1, 1, 1) | 32'h10);
        check("R12 sw bit reads 0", int'(bus_rdata), mk(0, 0, 1, 1, 1));
        push("R12 sw ignored", 2, 1'b0, 1'b0, 1'b0, 4'b1001);
        push("R12 sw ignored", 3, 1'b0, 1'b0, 1'b0, 4'b1001);
        push("R12 sw ignored", 4, 1'b0, 1'b0, 1'b0, 4'b1001);
        drain();

        // ---- R13: zero-event source ----
        setup(0, 0, 2, 0, 1, 1, 0);
        for (int n = 0; n < 9; n++) begin
            push("R13 zero source", n % 3, 1'b1, (n % 3) == 0, (n % 3) == 0, 4'b1111);
        end
        drain();

        // ---- R13: compare-B source ----
        setup(0, 0, 9, 0, 2, 1, 0);
        @(posedge clk);
        #1;
        cmpb_hit = 1'b1;
        sync_in  = 1'b1;
        push("R13 cmpb source high", 1, 1'b0, 1'b0, 1'b1, 4'b1001);
        @(posedge clk);
        #1;
        cmpb_hit = 1'b0;
        push("R13 cmpb source low", 2, 1'b0, 1'b0, 1'b0, 4'b1001);
        drain();

        // ---- R13: disabled output ----
        setup(0, 0, 0, 0, 3, 1, 0);
        @(posedge clk);
        #1;
        sync_in = 1'b1;
        push("R13 output off", 0, 1'b1, 1'b1, 1'b0, 4'b1000);
        push("R13 output off", 0, 1'b1, 1'b1, 1'b0, 4'b1000);
        drain();
        sync_in = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule